// File: doc/BRIEF.md
# Masked Byte Insert Unit

This unit merges a run of memory bytes into a 32-bit general register. A start pulse captures the current register value, a four-bit lane mask, a byte address and an incoming condition code. The unit then reads bytes one at a time over a request/valid byte port, beginning at that address. It drops each byte into the next selected register lane, working from the most significant lane towards the least. At the end it presents the merged register and a two-bit condition code, and pulses `done` for one cycle. A second mode replaces only the least significant byte and passes the incoming condition code through unchanged.

The unit also reports how many bytes the surrounding pipeline must access-check for the operation. It stops cleanly when the memory side signals an access fault. The control state machine has three states. `ST_IDLE` waits for `start`. `ST_READ` holds a byte request until data or a fault returns. `ST_DONE` presents the result for one cycle. Its transitions are: idle-to-read (start with a nonzero mask, or single-byte mode), idle-to-done (start with a zero mask in masked mode), read-to-read (byte accepted with lanes still pending), read-to-done (last byte accepted, or a fault) and done-to-idle (always).

Top module: `byte_insert_unit`

## Requirements
- R1: Mask bit 3 selects register bits 31:24, bit 2 selects 23:16, bit 1 selects 15:8 and bit 0 selects 7:0.
- R2: Selected lanes are filled from the most significant selected lane down to the least, using bytes from the start address, then start+1, and so on.
- R3: In masked mode, the number of bytes read equals the number of ones in the mask. A zero mask issues no read and returns the register unchanged.
- R4: Register lanes whose mask bit is zero keep their prior contents.
- R5: In masked mode, `cc_out` is 0 when the mask is zero or when every inserted bit is zero.
- R6: When some inserted bit is one, `cc_out` is 1 if bit 7 of the first byte read is set, and 2 otherwise. Masked mode never yields 3.
- R7: `check_len` equals the popcount of the mask when the mask is nonzero. It is 1 for a zero mask and 1 in single-byte mode. It is valid from the cycle after start until the next start.
- R8: With `single_mode` high, one byte is read from the start address into bits 7:0. Bits 31:8 are kept, the mask is ignored, and `cc_out` equals the `cc_in` captured at start.
- R9: `mem_req` and `mem_addr` hold steady until `mem_valid` or `mem_fault` arrives. Each accepted byte advances the address by one.
- R10: A `mem_fault` during a read ends the operation. `fault` is then high with `done`, `reg_out` equals the captured `reg_in`, `cc_out` equals the captured `cc_in`, and no further request is made.
- R11: A `start` pulse while `busy` is high has no effect on the running operation or its result.
- R12: `done` is high for exactly one cycle per operation, and `busy` is high from the cycle after start through the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| single_mode | input | 1 | 1 = single low-byte insert, 0 = masked insert |
| reg_in | input | 32 | Register value before the insert |
| lane_mask | input | 4 | Lane select mask, bit 3 = bits 31:24 |
| addr_in | input | 32 | Address of the first memory byte |
| cc_in | input | 2 | Condition code held before the operation |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 32 | Byte read address |
| mem_valid | input | 1 | Read data valid |
| mem_data | input | 8 | Read data byte |
| mem_fault | input | 1 | Access fault for the pending request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Operation ended on an access fault |
| reg_out | output | 32 | Resulting register value |
| cc_out | output | 2 | Resulting condition code |
| check_len | output | 3 | Number of bytes to access-check |

## Verification
The masked insert is run with four mask patterns, each aimed at a different question. A full mask and two sparse masks show whether packed source bytes reach the right lanes in the right order, and whether unselected lanes survive. A zero mask shows that no read is made. A byte set that is all zero separates condition code 0 from code 2. Two sparse cases separate a first-byte sign bit from a set bit elsewhere, which pins condition code 1 against 2. Added response latency, a fault on the third byte and a stray start during a read each test the request protocol apart from the merge logic.

// File: rtl/bins_pkg.sv
package bins_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_DONE = 2'd2
    } bins_state_e;

    localparam logic [1:0] CC_ZERO = 2'd0;
    localparam logic [1:0] CC_NEG  = 2'd1;
    localparam logic [1:0] CC_POS  = 2'd2;
endpackage

// File: rtl/bins_lane_pick.sv
module bins_lane_pick #(
    parameter int LANES  = 4,
    parameter int LIDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0]  pending,
    output logic [LIDX_W-1:0] lane,
    output logic              last
);
    // highest pending lane is the next one to fill
    always_comb begin
        lane = '0;
        for (int i = 0; i < LANES; i++) begin
            if (pending[i]) lane = LIDX_W'(i);
        end
        last = ($countones(pending) == 1);
    end
endmodule

// File: rtl/bins_check_len.sv
module bins_check_len #(
    parameter int LANES = 4,
    parameter int CNT_W = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0] mask,
    input  logic             single,
    output logic [CNT_W-1:0] len
);
    logic [CNT_W-1:0] ones;

    always_comb begin
        ones = '0;
        for (int i = 0; i < LANES; i++) begin
            ones = ones + CNT_W'(mask[i]);
        end
        if (single || ones == '0) len = CNT_W'(1);
        else                      len = ones;
    end
endmodule

// File: rtl/bins_lane_merge.sv
module bins_lane_merge #(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    parameter int LIDX_W = $clog2(LANES)
) (
    input  logic [LANES*BYTE_W-1:0] cur,
    input  logic [BYTE_W-1:0]       byte_in,
    input  logic [LIDX_W-1:0]       lane,
    output logic [LANES*BYTE_W-1:0] nxt
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign nxt[g*BYTE_W +: BYTE_W] =
            (lane == LIDX_W'(g)) ? byte_in : cur[g*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/byte_insert_unit.sv
module byte_insert_unit
    import bins_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          single_mode,
    input  logic [LANES*BYTE_W-1:0]       reg_in,
    input  logic [LANES-1:0]              lane_mask,
    input  logic [ADDR_W-1:0]             addr_in,
    input  logic [1:0]                    cc_in,
    output logic                          mem_req,
    output logic [ADDR_W-1:0]             mem_addr,
    input  logic                          mem_valid,
    input  logic [BYTE_W-1:0]             mem_data,
    input  logic                          mem_fault,
    output logic                          busy,
    output logic                          done,
    output logic                          fault,
    output logic [LANES*BYTE_W-1:0]       reg_out,
    output logic [1:0]                    cc_out,
    output logic [$clog2(LANES+1)-1:0]    check_len
);
    localparam int DATA_W = LANES * BYTE_W;
    localparam int LIDX_W = $clog2(LANES);
    localparam int CNT_W  = $clog2(LANES + 1);

    bins_state_e          state_q, state_d;
    logic [ADDR_W-1:0]    base_q;
    logic [CNT_W-1:0]     offset_q;
    logic [LANES-1:0]     pending_q;
    logic [DATA_W-1:0]    work_q, orig_q;
    logic [1:0]           cc_hold_q;
    logic                 single_q, any_nz_q, first_msb_q, first_seen_q, fault_q;
    logic [CNT_W-1:0]     len_q, len_calc;
    logic [LIDX_W-1:0]    lane_sel;
    logic                 lane_last;
    logic [DATA_W-1:0]    merged;
    logic                 take_start, accept;

    bins_lane_pick #(.LANES(LANES), .LIDX_W(LIDX_W)) u_pick (
        .pending (pending_q),
        .lane    (lane_sel),
        .last    (lane_last)
    );

    bins_check_len #(.LANES(LANES), .CNT_W(CNT_W)) u_len (
        .mask   (lane_mask),
        .single (single_mode),
        .len    (len_calc)
    );

    bins_lane_merge #(.LANES(LANES), .BYTE_W(BYTE_W), .LIDX_W(LIDX_W)) u_merge (
        .cur     (work_q),
        .byte_in (mem_data),
        .lane    (lane_sel),
        .nxt     (merged)
    );

    assign take_start = (state_q == ST_IDLE) && start;
    assign accept     = (state_q == ST_READ) && mem_valid && !mem_fault;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (!single_mode && lane_mask == '0) state_d = ST_DONE;
                    else                                 state_d = ST_READ;
                end
            end
            ST_READ: begin
                if (mem_fault)                   state_d = ST_DONE;
                else if (mem_valid && lane_last) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // operation context and byte accumulation
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q       <= '0;
            offset_q     <= '0;
            pending_q    <= '0;
            work_q       <= '0;
            orig_q       <= '0;
            cc_hold_q    <= CC_ZERO;
            single_q     <= 1'b0;
            any_nz_q     <= 1'b0;
            first_msb_q  <= 1'b0;
            first_seen_q <= 1'b0;
            fault_q      <= 1'b0;
            len_q        <= '0;
        end else if (take_start) begin
            base_q       <= addr_in;
            offset_q     <= '0;
            pending_q    <= single_mode ? LANES'(1) : lane_mask;
            work_q       <= reg_in;
            orig_q       <= reg_in;
            cc_hold_q    <= cc_in;
            single_q     <= single_mode;
            any_nz_q     <= 1'b0;
            first_msb_q  <= 1'b0;
            first_seen_q <= 1'b0;
            fault_q      <= 1'b0;
            len_q        <= len_calc;
        end else if (state_q == ST_READ) begin
            if (mem_fault) begin
                fault_q <= 1'b1;
            end else if (mem_valid) begin
                work_q    <= merged;
                pending_q <= pending_q & ~(LANES'(1) << lane_sel);
                offset_q  <= offset_q + CNT_W'(1);
                any_nz_q  <= any_nz_q | (|mem_data);
                if (!first_seen_q) begin
                    first_seen_q <= 1'b1;
                    first_msb_q  <= mem_data[BYTE_W-1];
                end
            end
        end
    end

    // outputs
    always_comb begin
        mem_req   = (state_q == ST_READ);
        mem_addr  = base_q + ADDR_W'(offset_q);
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        fault     = fault_q;
        check_len = len_q;
        reg_out   = fault_q ? orig_q : work_q;
        if (fault_q || single_q)  cc_out = cc_hold_q;
        else if (!any_nz_q)       cc_out = CC_ZERO;
        else if (first_msb_q)     cc_out = CC_NEG;
        else                      cc_out = CC_POS;
    end

    // request stays put until answered
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid && !mem_fault) |=> (mem_req && $stable(mem_addr)));

    // consecutive bytes come from consecutive addresses
    assert_addr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_valid && !mem_fault && mem_req && !lane_last)
            |=> (mem_req && mem_addr == $past(mem_addr) + ADDR_W'(1)));

    // zero mask in masked mode never touches memory
    assert_zero_noreq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (take_start && !single_mode && lane_mask == '0) |=> (!mem_req && done));

    assert_cc_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault && !single_q) |-> (cc_out != 2'b11));

    assert_len_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (check_len >= CNT_W'(1) && check_len <= CNT_W'(LANES)));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // a fault cuts off all further requests
    assert_fault_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_fault) |=> (!mem_req && fault && done));
endmodule

// File: tb/byte_insert_unit_tb.sv
`timescale 1ns/1ps
module byte_insert_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        single_mode = 1'b0;
    logic [31:0] reg_in = '0;
    logic [3:0]  lane_mask = '0;
    logic [31:0] addr_in = '0;
    logic [1:0]  cc_in = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [7:0]  mem_data = '0;
    logic        mem_fault = 1'b0;
    logic        busy, done, fault;
    logic [31:0] reg_out;
    logic [1:0]  cc_out;
    logic [2:0]  check_len;

    int checks = 0;
    int fails  = 0;

    logic [7:0]  mem [0:15];
    int          lat = 0;
    int          wait_cnt = 0;
    int          nread = 0;
    int          addr_err = 0;
    logic [31:0] exp_addr;
    logic        flt_en = 1'b0;
    logic [31:0] flt_addr = '0;

    always #2.5 clk = ~clk;

    byte_insert_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .single_mode(single_mode),
        .reg_in(reg_in), .lane_mask(lane_mask), .addr_in(addr_in), .cc_in(cc_in),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_data(mem_data), .mem_fault(mem_fault), .busy(busy), .done(done),
        .fault(fault), .reg_out(reg_out), .cc_out(cc_out), .check_len(check_len)
    );

    // memory responder, driven on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            mem_valid = 1'b0;
            mem_fault = 1'b0;
            if (mem_req) begin
                if (wait_cnt >= lat) begin
                    wait_cnt = 0;
                    if (flt_en && mem_addr == flt_addr) begin
                        mem_fault = 1'b1;
                    end else begin
                        if (mem_addr != exp_addr) addr_err++;
                        exp_addr  = exp_addr + 1;
                        mem_valid = 1'b1;
                        mem_data  = mem[mem_addr[3:0]];
                        nread++;
                    end
                end else begin
                    wait_cnt++;
                end
            end else begin
                wait_cnt = 0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic launch(input logic sm, input logic [31:0] r, input logic [3:0] m,
                          input logic [31:0] a, input logic [1:0] c);
        @(negedge clk);
        single_mode = sm; reg_in = r; lane_mask = m; addr_in = a; cc_in = c;
        nread = 0; addr_err = 0; exp_addr = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (done !== 1'b1 && n < 200) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_pulse(input string req);
        @(negedge clk);
        chk({req, " done drops"}, {31'd0, done}, 32'd0);
        chk({req, " busy drops"}, {31'd0, busy}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R12 reset busy", {31'd0, busy}, 32'd0);
        chk("R12 reset done", {31'd0, done}, 32'd0);
        chk("R9 reset req", {31'd0, mem_req}, 32'd0);
        chk("R10 reset fault", {31'd0, fault}, 32'd0);
    endtask

    task automatic t_full_mask();
        mem[4] = 8'h11; mem[5] = 8'h22; mem[6] = 8'h33; mem[7] = 8'h44;
        launch(1'b0, 32'hA5A5A5A5, 4'hF, 32'd4, 2'd3);
        chk("R12 busy while reading", {31'd0, busy}, 32'd1);
        chk("R7 len full", {29'd0, check_len}, 32'd4);
        wait_done();
        chk("R1 R2 full order", reg_out, 32'h11223344);
        chk("R3 full reads", nread, 4);
        chk("R6 cc positive", {30'd0, cc_out}, 32'd2);
        chk("R9 address run", addr_err, 0);
        finish_pulse("R12");
    endtask

    task automatic t_sparse_neg();
        mem[8] = 8'h81; mem[9] = 8'h7F;
        launch(1'b0, 32'hAABBCCDD, 4'b1010, 32'd8, 2'd0);
        chk("R7 len sparse", {29'd0, check_len}, 32'd2);
        wait_done();
        chk("R4 sparse 1010", reg_out, 32'h81BB7FDD);
        chk("R3 sparse reads", nread, 2);
        chk("R6 cc negative", {30'd0, cc_out}, 32'd1);
        finish_pulse("R12");
    endtask

    task automatic t_sparse_pos();
        mem[12] = 8'h00; mem[13] = 8'h85;
        launch(1'b0, 32'hDEADBEEF, 4'b0101, 32'd12, 2'd1);
        wait_done();
        chk("R4 sparse 0101", reg_out, 32'hDE00BE85);
        chk("R6 first byte decides", {30'd0, cc_out}, 32'd2);
        finish_pulse("R12");
    endtask

    task automatic t_all_zero();
        mem[0] = 8'h00; mem[1] = 8'h00;
        launch(1'b0, 32'hFFFFFFFF, 4'b0011, 32'd0, 2'd2);
        wait_done();
        chk("R5 zero bytes value", reg_out, 32'hFFFF0000);
        chk("R5 zero bytes cc", {30'd0, cc_out}, 32'd0);
        finish_pulse("R12");
    endtask

    task automatic t_zero_mask();
        launch(1'b0, 32'h12345678, 4'b0000, 32'd3, 2'd3);
        chk("R7 len zero mask", {29'd0, check_len}, 32'd1);
        wait_done();
        chk("R3 zero mask reads", nread, 0);
        chk("R3 zero mask value", reg_out, 32'h12345678);
        chk("R5 zero mask cc", {30'd0, cc_out}, 32'd0);
        finish_pulse("R12");
    endtask

    task automatic t_single();
        mem[5] = 8'h9C; mem[6] = 8'hEE;
        launch(1'b1, 32'h11223344, 4'hF, 32'd5, 2'd3);
        chk("R7 len single", {29'd0, check_len}, 32'd1);
        wait_done();
        chk("R8 single value", reg_out, 32'h1122339C);
        chk("R8 single reads", nread, 1);
        chk("R8 single cc kept", {30'd0, cc_out}, 32'd3);
        finish_pulse("R12");
    endtask

    task automatic t_latency();
        mem[10] = 8'h01; mem[11] = 8'h02; mem[12] = 8'h03;
        lat = 2;
        launch(1'b0, 32'h00000000, 4'b1110, 32'd10, 2'd0);
        wait_done();
        lat = 0;
        chk("R9 slow memory value", reg_out, 32'h01020300);
        chk("R9 slow memory addresses", addr_err, 0);
        finish_pulse("R12");
    endtask

    task automatic t_fault();
        mem[0] = 8'h55; mem[1] = 8'h66;
        flt_en = 1'b1; flt_addr = 32'd2;
        launch(1'b0, 32'hCAFEF00D, 4'hF, 32'd0, 2'd2);
        wait_done();
        flt_en = 1'b0;
        chk("R10 fault flag", {31'd0, fault}, 32'd1);
        chk("R10 fault value", reg_out, 32'hCAFEF00D);
        chk("R10 fault cc", {30'd0, cc_out}, 32'd2);
        chk("R10 reads before fault", nread, 2);
        @(negedge clk);
        chk("R10 no request after", {31'd0, mem_req}, 32'd0);
    endtask

    task automatic t_busy_start();
        mem[4] = 8'hA1; mem[5] = 8'hB2;
        lat = 3;
        launch(1'b0, 32'h01020304, 4'b1100, 32'd4, 2'd0);
        @(negedge clk);
        single_mode = 1'b1; reg_in = 32'hFFFFFFFF; lane_mask = 4'b0001;
        addr_in = 32'd9; cc_in = 2'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        lat = 0;
        chk("R11 start while busy value", reg_out, 32'hA1B20304);
        chk("R11 start while busy cc", {30'd0, cc_out}, 32'd1);
        chk("R11 start while busy len", {29'd0, check_len}, 32'd2);
        finish_pulse("R12");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_full_mask();
        t_sparse_neg();
        t_sparse_pos();
        t_all_zero();
        t_zero_mask();
        t_single();
        t_latency();
        t_fault();
        t_busy_start();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule